// File: doc/BRIEF.md
# Interpolating Packet Timestamp Reframer

This block sits after a sample-rate interpolator. It takes the expanded sample stream, whose words each hold several samples, and cuts it into output packets of a fixed number of samples. Each input packet, once interpolated by the current rate, becomes that many output packets. The block gives each output packet its own metadata. The has-time flag follows the input. The timestamp starts at the input timestamp of the first packet of a burst and then climbs by one packet's worth of samples per output packet. The end-of-burst flag appears only on the very last output packet of the burst.

Both sides use valid/ready handshakes. Sideband fields on the input (`s_has_time`, `s_time`, `s_eob`) are read only on the first word of each output packet. On every other word they are ignored. The rate input is read at each packet start and must stay constant across one input packet's expansion.

A small state machine steers the framing. Its states are:
- `ST_BURST_HEAD`: the next word opens a burst, and the timestamp reloads from the input.
- `ST_PKT_HEAD`: the next word opens a further packet of the same burst.
- `ST_PKT_BODY`: a packet is in progress.

Its transitions, all taken on an accepted word, are:
- `open`: a head state goes to `ST_PKT_BODY` when the word is not the last of its packet.
- `close_mid`: the packet's last word goes to `ST_PKT_HEAD` when the packet carries no end-of-burst.
- `close_burst`: the packet's last word goes to `ST_BURST_HEAD` when the packet carries end-of-burst.

Top module: `rfr_reframer`

## Requirements
- R1: While reset is held and right after it, `m_valid` is 0; with no input offered after reset, `s_ready` is 1.
- R2: Every output packet holds exactly PKT_WORDS = SPP / (WORD_W / SAMP_W) words (64 by default), and `m_last` is 1 on exactly its final word.
- R3: Data words leave in the order they arrived, unchanged, with none lost or repeated.
- R4: Each input packet yields `interp_rate` output packets, and a rate of 0 is treated as 1. A burst of N input packets therefore gives rate×N output packets.
- R5: The first output packet after reset carries `m_time` equal to `s_time` on its first input word.
- R6: Each later output packet of a burst carries the previous packet's timestamp plus SPP. The `s_time` values presented on those packets' first words are not used.
- R7: `m_has_time` equals `s_has_time` on the packet's first word and is constant over the packet.
- R8: `m_eob` is 1 on all words of a packet exactly when `s_eob` was 1 on that packet's first word and the packet is the last (rate-th) of its input packet's group; it is 0 on all other packets.
- R9: After a packet with end-of-burst, the next packet's timestamp reloads from `s_time` on its first word.
- R10: While `m_valid` is 1 and `m_ready` is 0, the output word and its metadata hold steady and `s_ready` is 0.
- R11: Sideband inputs on words other than a packet's first word have no effect on any output metadata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interp_rate | input | RATE_W | Output packets per input packet (0 acts as 1) |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted when high with s_valid |
| s_data | input | WORD_W | Input sample word |
| s_has_time | input | 1 | Input has-time flag, read at packet start |
| s_time | input | TIME_W | Input timestamp, read at burst start |
| s_eob | input | 1 | Input end-of-burst flag, read at packet start |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | WORD_W | Output sample word |
| m_last | output | 1 | Final word of output packet |
| m_has_time | output | 1 | Packet has-time flag |
| m_time | output | TIME_W | Packet timestamp |
| m_eob | output | 1 | Packet end-of-burst flag |

## Verification
The bound checker checks several properties on every cycle:
- An output held under backpressure stays steady.
- `m_last` falls exactly on every PKT_WORDS-th accepted word.
- Metadata is constant within a packet.
- Inside a burst, each packet's timestamp exceeds the previous one by SPP.

Other behaviours depend on what was offered at the input, so only the bench's scenarios can show them:
- The packet count per input group and the rate-0 case.
- Placement of end-of-burst on the rate-th packet of the final group.
- Reload of the timestamp at a new burst.
- That garbage sideband on non-head words is ignored.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

    typedef enum logic [1:0] {
        ST_BURST_HEAD = 2'd0,
        ST_PKT_HEAD   = 2'd1,
        ST_PKT_BODY   = 2'd2
    } rfr_state_e;

endpackage

// File: rtl/rfr_word_count.sv
module rfr_word_count #(
    parameter int PKT_WORDS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic word_last
);
    localparam int CNT_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;

    generate
        if (PKT_WORDS == 1) begin : g_single
            assign word_last = 1'b1;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (adv) begin
                    cnt_q <= word_last ? '0 : cnt_q + 1'b1;
                end
            end
            assign word_last = (cnt_q == CNT_W'(PKT_WORDS - 1));
        end
    endgenerate
endmodule

// File: rtl/rfr_grp_count.sv
module rfr_grp_count #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              at_head,
    input  logic              head_take,
    input  logic              pkt_end,
    output logic              grp_last
);
    logic [RATE_W-1:0] grp_cnt_q;
    logic              grp_last_q;
    logic [RATE_W:0]   rate_eff;
    logic [RATE_W:0]   cnt_next;
    logic              grp_last_now;

    always_comb begin
        rate_eff     = (rate == '0) ? (RATE_W+1)'(1) : {1'b0, rate};
        cnt_next     = {1'b0, grp_cnt_q} + 1'b1;
        grp_last_now = (cnt_next >= rate_eff);
        grp_last     = at_head ? grp_last_now : grp_last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_cnt_q  <= '0;
            grp_last_q <= 1'b0;
        end else begin
            if (head_take) begin
                grp_last_q <= grp_last_now;
            end
            if (pkt_end) begin
                grp_cnt_q <= grp_last ? '0 : cnt_next[RATE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rfr_time_gen.sv
module rfr_time_gen #(
    parameter int TIME_W = 64,
    parameter int SPP    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_head,
    input  logic              head_take,
    input  logic [TIME_W-1:0] in_time,
    output logic [TIME_W-1:0] cur_time
);
    logic [TIME_W-1:0] next_q;

    assign cur_time = burst_head ? in_time : next_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
        end else if (head_take) begin
            next_q <= cur_time + TIME_W'(SPP);
        end
    end
endmodule

// File: rtl/rfr_out_stage.sv
module rfr_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout,
    output logic         free
);
    assign free = !valid || ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/rfr_reframer.sv
module rfr_reframer
    import rfr_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int SAMP_W = 32,
    parameter int SPP    = 128,
    parameter int TIME_W = 64,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] interp_rate,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [WORD_W-1:0] s_data,
    input  logic              s_has_time,
    input  logic [TIME_W-1:0] s_time,
    input  logic              s_eob,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [WORD_W-1:0] m_data,
    output logic              m_last,
    output logic              m_has_time,
    output logic [TIME_W-1:0] m_time,
    output logic              m_eob
);
    localparam int SAMPS_PER_WORD = WORD_W / SAMP_W;
    localparam int PKT_WORDS      = SPP / SAMPS_PER_WORD;
    localparam int OUT_W          = WORD_W + 1 + 1 + TIME_W + 1;

    rfr_state_e        state_q, state_d;
    logic              take, at_head, burst_head, head_take, word_last, pkt_end;
    logic              grp_last;
    logic [TIME_W-1:0] cur_time;
    logic              meta_ht_q, meta_eob_q;
    logic [TIME_W-1:0] meta_time_q;
    logic              beat_ht, beat_eob;
    logic [TIME_W-1:0] beat_time;
    logic [OUT_W-1:0]  out_din, out_dout;

    assign take       = s_valid && s_ready;
    assign at_head    = (state_q != ST_PKT_BODY);
    assign burst_head = (state_q == ST_BURST_HEAD);
    assign head_take  = take && at_head;
    assign pkt_end    = take && word_last;

    rfr_word_count #(.PKT_WORDS(PKT_WORDS)) u_wcnt (
        .clk(clk), .rst_n(rst_n), .adv(take), .word_last(word_last)
    );

    rfr_grp_count #(.RATE_W(RATE_W)) u_gcnt (
        .clk(clk), .rst_n(rst_n), .rate(interp_rate), .at_head(at_head),
        .head_take(head_take), .pkt_end(pkt_end), .grp_last(grp_last)
    );

    rfr_time_gen #(.TIME_W(TIME_W), .SPP(SPP)) u_tgen (
        .clk(clk), .rst_n(rst_n), .burst_head(burst_head),
        .head_take(head_take), .in_time(s_time), .cur_time(cur_time)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BURST_HEAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: open / close_mid / close_burst
    always_comb begin
        state_d = state_q;
        if (take) begin
            unique case (state_q)
                ST_BURST_HEAD, ST_PKT_HEAD, ST_PKT_BODY: begin
                    if (!word_last) begin
                        state_d = ST_PKT_BODY;
                    end else if (beat_eob) begin
                        state_d = ST_BURST_HEAD;
                    end else begin
                        state_d = ST_PKT_HEAD;
                    end
                end
                default: state_d = ST_BURST_HEAD;
            endcase
        end
    end

    // Per-beat metadata: fresh at a head, held in the body
    always_comb begin
        unique case (state_q)
            ST_BURST_HEAD, ST_PKT_HEAD: begin
                beat_ht   = s_has_time;
                beat_time = cur_time;
                beat_eob  = s_eob && grp_last;
            end
            default: begin
                beat_ht   = meta_ht_q;
                beat_time = meta_time_q;
                beat_eob  = meta_eob_q;
            end
        endcase
        out_din = {s_data, word_last, beat_ht, beat_time, beat_eob};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_ht_q   <= 1'b0;
            meta_time_q <= '0;
            meta_eob_q  <= 1'b0;
        end else if (head_take) begin
            meta_ht_q   <= beat_ht;
            meta_time_q <= beat_time;
            meta_eob_q  <= beat_eob;
        end
    end

    rfr_out_stage #(.W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(take), .din(out_din),
        .ready(m_ready), .valid(m_valid), .dout(out_dout), .free(s_ready)
    );

    assign {m_data, m_last, m_has_time, m_time, m_eob} = out_dout;

endmodule

// File: rtl/rfr_reframer_chk.sv
module rfr_reframer_chk #(
    parameter int WORD_W    = 64,
    parameter int TIME_W    = 64,
    parameter int SPP       = 128,
    parameter int PKT_WORDS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_valid,
    input logic              m_ready,
    input logic [WORD_W-1:0] m_data,
    input logic              m_last,
    input logic              m_has_time,
    input logic [TIME_W-1:0] m_time,
    input logic              m_eob
);
    localparam int CW = $clog2(PKT_WORDS + 1);

    logic              acc;
    logic [CW-1:0]     beat_cnt;
    logic              started, prev_eob, hold_ht;
    logic [TIME_W-1:0] hold_time;

    assign acc = m_valid && m_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt  <= '0;
            started   <= 1'b0;
            prev_eob  <= 1'b0;
            hold_ht   <= 1'b0;
            hold_time <= '0;
        end else if (acc) begin
            beat_cnt  <= (beat_cnt == CW'(PKT_WORDS - 1)) ? '0 : beat_cnt + 1'b1;
            started   <= 1'b1;
            prev_eob  <= m_eob;
            hold_ht   <= m_has_time;
            hold_time <= m_time;
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)
                                   && $stable(m_time) && $stable(m_eob)));

    p_last_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (m_last == (beat_cnt == CW'(PKT_WORDS - 1))));

    p_meta_const_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && beat_cnt != '0) |-> (m_time == hold_time && m_has_time == hold_ht
                                     && m_eob == prev_eob));

    p_time_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && beat_cnt == '0 && started && !prev_eob)
            |-> (m_time == hold_time + TIME_W'(SPP)));
endmodule

bind rfr_reframer rfr_reframer_chk #(
    .WORD_W(WORD_W), .TIME_W(TIME_W), .SPP(SPP), .PKT_WORDS(PKT_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .m_has_time(m_has_time),
    .m_time(m_time), .m_eob(m_eob)
);

// File: tb/tb_rfr_reframer.sv
module tb_rfr_reframer;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 64;
    localparam int SAMP_W     = 32;
    localparam int SPP        = 128;
    localparam int TIME_W     = 64;
    localparam int RATE_W     = 8;
    localparam int PKT_WORDS  = SPP / (WORD_W / SAMP_W);
    localparam int MAX_CYC    = 190000;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              ht;
        logic [TIME_W-1:0] tm;
        logic              eob;
    } in_beat_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              last;
        logic              ht;
        logic [TIME_W-1:0] tm;
        logic              eob;
        logic [3:0]        ttag;
    } exp_beat_t;

    logic clk = 0, rst_n = 0;
    logic [RATE_W-1:0] interp_rate = 1;
    logic s_valid = 0, s_ready, s_has_time = 0, s_eob = 0;
    logic [WORD_W-1:0] s_data = '0;
    logic [TIME_W-1:0] s_time = '0;
    logic m_valid, m_ready = 0, m_last, m_has_time, m_eob;
    logic [WORD_W-1:0] m_data;
    logic [TIME_W-1:0] m_time;

    int n_chk = 0, n_bad = 0, n_bursts = 0;
    bit done = 0;
    in_beat_t  in_q[$];
    exp_beat_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rfr_reframer #(.WORD_W(WORD_W), .SAMP_W(SAMP_W), .SPP(SPP),
                   .TIME_W(TIME_W), .RATE_W(RATE_W)) dut (
        .clk(clk), .rst_n(rst_n), .interp_rate(interp_rate),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_has_time(s_has_time), .s_time(s_time), .s_eob(s_eob),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .m_has_time(m_has_time), .m_time(m_time), .m_eob(m_eob)
    );

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic string ttag_name(logic [3:0] t);
        case (t)
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd9:    return "R9";
            default: return "R11";
        endcase
    endfunction

    // Build stimulus and expectation for one burst
    task automatic build_burst(int rate, int npk, bit ht, logic [TIME_W-1:0] start);
        int re = (rate == 0) ? 1 : rate;
        int k = 0;
        for (int g = 0; g < npk; g++) begin
            for (int p = 0; p < re; p++) begin
                for (int w = 0; w < PKT_WORDS; w++) begin
                    in_beat_t  ib;
                    exp_beat_t eb;
                    ib.data = {$urandom, $urandom};
                    if (w == 0) begin
                        ib.ht  = ht;
                        ib.tm  = start + TIME_W'(g * SPP) + TIME_W'(p * 7);
                        ib.eob = (g == npk - 1);
                    end else begin
                        ib.ht  = $urandom_range(0, 1);
                        ib.tm  = {$urandom, $urandom};
                        ib.eob = $urandom_range(0, 1);
                    end
                    eb.data = ib.data;
                    eb.last = (w == PKT_WORDS - 1);
                    eb.ht   = ht;
                    eb.tm   = start + TIME_W'(k * SPP);
                    eb.eob  = (g == npk - 1) && (p == re - 1);
                    eb.ttag = (w != 0) ? 4'd11 : (k == 0) ? ((n_bursts == 0) ? 4'd5 : 4'd9) : 4'd6;
                    in_q.push_back(ib);
                    exp_q.push_back(eb);
                end
                k++;
            end
        end
    endtask

    task automatic run_burst(int rate, int npk, bit ht, logic [TIME_W-1:0] start,
                             int vprob, int rprob);
        int re = (rate == 0) ? 1 : rate;
        int pkts = 0;
        bit prev_stall = 0;
        logic [WORD_W-1:0] prev_data = '0;
        logic [TIME_W-1:0] prev_time = '0;
        interp_rate = RATE_W'(rate);
        build_burst(rate, npk, ht, start);
        while (in_q.size() != 0 || exp_q.size() != 0) begin
            @(negedge clk);
            s_valid = (in_q.size() != 0) && ($urandom_range(1, 100) <= vprob);
            if (in_q.size() != 0) begin
                s_data = in_q[0].data; s_has_time = in_q[0].ht;
                s_time = in_q[0].tm;   s_eob = in_q[0].eob;
            end
            m_ready = ($urandom_range(1, 100) <= rprob);
            #1;
            if (prev_stall) begin
                check(m_valid && m_data == prev_data && m_time == prev_time, "R10 hold",
                      {m_valid, m_data}, {1'b1, prev_data});
            end
            if (m_valid && !m_ready) begin
                check(!s_ready, "R10 s_ready", s_ready, 0);
            end
            prev_stall = m_valid && !m_ready;
            prev_data  = m_data;
            prev_time  = m_time;
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R3 extra word", m_data, 0);
                end else begin
                    exp_beat_t e = exp_q.pop_front();
                    check(m_data == e.data, "R3 data", m_data, e.data);
                    check(m_last == e.last, "R2 last", m_last, e.last);
                    check(m_has_time == e.ht, "R7 has_time", m_has_time, e.ht);
                    check(m_time == e.tm, ttag_name(e.ttag), m_time, e.tm);
                    check(m_eob == e.eob, "R8 eob", m_eob, e.eob);
                    if (m_last) pkts++;
                end
            end
            if (s_valid && s_ready) void'(in_q.pop_front());
        end
        @(negedge clk);
        s_valid = 0; m_ready = 0;
        check(pkts == re * npk, "R4 packet count", pkts, re * npk);
        n_bursts++;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) begin
            @(negedge clk);
            check(m_valid == 0, "R1 valid in reset", m_valid, 0);
        end
        rst_n = 1;
        @(negedge clk); #1;
        check(m_valid == 0, "R1 valid after reset", m_valid, 0);
        check(s_ready == 1, "R1 ready after reset", s_ready, 1);
        // Directed corners
        run_burst(1, 1, 1, 64'h0123_4567_89AB_CDEF, 100, 100);
        run_burst(0, 2, 0, 64'h0000_0000_0000_1000, 80, 80);
        run_burst(3, 2, 1, 64'hFFFF_FFFF_FFFF_FF80, 100, 100);
        run_burst(5, 1, 1, 64'h0000_0000_0000_0042, 90, 25);
        // Random bursts
        for (int b = 0; b < 8; b++) begin
            run_burst($urandom_range(1, 6), $urandom_range(1, 3), $urandom_range(0, 1),
                      {$urandom, $urandom}, $urandom_range(40, 100), $urandom_range(40, 100));
        end
        summary();
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end
endmodule